// File: doc/BRIEF.md
# Clock Page Replacement Selector

This block picks the next physical frame to give up when memory is full. It holds a small descriptor table with one entry per frame: referenced, dirty and pinned flags plus a last-use timestamp. When a select request arrives, a circular hand sweeps the table one frame per cycle and gives a second chance to recently referenced frames. Frames waiting for I/O are left alone. Each dirty frame it passes is announced on a write-back stream, and the sweep then moves on. The first clean frame that qualifies is returned as the victim.

An optional working-set mode adds an age test. In this mode, a frame whose last use is within a programmable window of the current virtual time is kept, even when its referenced flag is clear. The descriptor table is loaded through a single write port, which the surrounding logic uses while the selector is idle. A combinational read port shows any entry's fields. If the sweep covers the table twice without finding a victim, it gives up and reports failure.

Top module: `clk_victim_sel`

## Requirements
- R1: After reset the hand is at frame 0, the selector is idle, no done, fail or write-back beat is active, and every descriptor field (referenced, dirty, pinned, last-use) reads as zero.
- R2: A select request (`sel_req` high for one cycle while idle) starts the sweep at the current hand position, and the sweep examines one frame per cycle in increasing index order.
- R3: A frame that is not pinned and has its referenced flag set has that flag cleared, and the hand moves on without selecting it.
- R4: A frame that is not pinned, not referenced, not protected by the age test and dirty is announced once as a beat on `wb_valid`/`wb_idx`. The beat is held stable until `wb_ready` accepts it, and the hand then moves on. The frame is not selected and its dirty flag is left set.
- R5: The first frame that is not pinned, not referenced, not protected by the age test and clean becomes the victim. `done` pulses for one cycle with `victim` holding its index, and the hand then rests one position past the victim.
- R6: A pinned frame is never selected and never announced for write-back, and the sweep leaves all of its fields unchanged.
- R7: In working-set mode (`ws_mode`=1), a referenced frame that is not pinned has its last-use time set to `cur_time` in the same step that clears its referenced flag.
- R8: In working-set mode, a frame that is not referenced and not pinned is skipped when (`cur_time` − last-use) modulo 2^TIME_W is less than `ws_window`.
- R9: If 2×N_FRAMES frames are examined without a victim, `fail` pulses for one cycle, the selector returns to idle, and the hand ends where the sweep began.
- R10: The descriptor write port (`upd_en`) takes effect only while idle. A write offered during a sweep is dropped, and the frame's fields keep their previous values.
- R11: The hand wraps from frame N_FRAMES−1 to frame 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ws_mode | input | 1 | Enables the working-set age test and last-use stamping |
| cur_time | input | TIME_W | Current virtual time |
| ws_window | input | TIME_W | Working-set window T |
| upd_en | input | 1 | Descriptor write strobe (idle only) |
| upd_idx | input | IDX_W | Frame written |
| upd_ref | input | 1 | Referenced flag to write |
| upd_dirty | input | 1 | Dirty flag to write |
| upd_pin | input | 1 | Pinned flag to write |
| upd_last | input | TIME_W | Last-use time to write |
| rd_idx | input | IDX_W | Frame inspected by the read port |
| rd_ref | output | 1 | Referenced flag of `rd_idx` |
| rd_dirty | output | 1 | Dirty flag of `rd_idx` |
| rd_pin | output | 1 | Pinned flag of `rd_idx` |
| rd_last | output | TIME_W | Last-use time of `rd_idx` |
| sel_req | input | 1 | Start a victim search |
| busy | output | 1 | A sweep is in progress |
| done | output | 1 | One-cycle pulse: victim found |
| fail | output | 1 | One-cycle pulse: no victim in two revolutions |
| victim | output | IDX_W | Index of the selected frame |
| hand | output | IDX_W | Current clock hand position |
| wb_valid | output | 1 | Write-back beat valid |
| wb_ready | input | 1 | Write-back beat accepted |
| wb_idx | output | IDX_W | Frame that needs write-back |

## Verification
The assertions assume several things about the inputs. `sel_req` is raised only while `busy` is low. `ws_mode`, `cur_time` and `ws_window` stay constant for the whole of a sweep. No one expects a descriptor write to land while a sweep runs. The stimulus meets these assumptions: it pulses `sel_req` only from idle and changes the time inputs only between selections. It also offers a write during one sweep, and that write is expected to be dropped. The write-back consumer lowers `wb_ready` on a fixed pattern, so some beats wait for acceptance.

// File: rtl/clk_sel_pkg.sv
package clk_sel_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SCAN = 2'd1,
      ST_WB   = 2'd2
   } sweep_state_t;

   // Per-frame view presented to the sweep controller
   typedef struct packed {
      logic referenced;
      logic dirty;
      logic pinned;
   } frame_flags_t;

endpackage

// File: rtl/clk_frame_table.sv
module clk_frame_table #(
   parameter int N_FRAMES = 64,
   parameter int TIME_W   = 16,
   parameter int IDX_W    = $clog2(N_FRAMES)
) (
   input  logic              clk,
   input  logic              rst_n,
   // descriptor write port
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic              wr_ref,
   input  logic              wr_dirty,
   input  logic              wr_pin,
   input  logic [TIME_W-1:0] wr_last,
   // sweep side-effects
   input  logic              clr_en,
   input  logic              stamp_en,
   input  logic [TIME_W-1:0] stamp_time,
   input  logic [IDX_W-1:0]  scan_idx,
   output clk_sel_pkg::frame_flags_t scan_flags,
   output logic [TIME_W-1:0] scan_last,
   // inspection port
   input  logic [IDX_W-1:0]  rd_idx,
   output clk_sel_pkg::frame_flags_t rd_flags,
   output logic [TIME_W-1:0] rd_last,
   // flat views for checking
   output logic [N_FRAMES-1:0] pin_vec,
   output logic [N_FRAMES-1:0] dirty_vec
);

   logic [N_FRAMES-1:0] ref_q;
   logic [N_FRAMES-1:0] dirty_q;
   logic [N_FRAMES-1:0] pin_q;
   logic [TIME_W-1:0]   last_q [N_FRAMES];

   for (genvar g = 0; g < N_FRAMES; g++) begin : g_frame
      logic hit_wr;
      logic hit_scan;
      assign hit_wr   = wr_en && (wr_idx == IDX_W'(g));
      assign hit_scan = (scan_idx == IDX_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ref_q[g]   <= 1'b0;
            dirty_q[g] <= 1'b0;
            pin_q[g]   <= 1'b0;
            last_q[g]  <= '0;
         end else if (hit_wr) begin
            ref_q[g]   <= wr_ref;
            dirty_q[g] <= wr_dirty;
            pin_q[g]   <= wr_pin;
            last_q[g]  <= wr_last;
         end else if (hit_scan) begin
            if (clr_en)   ref_q[g]  <= 1'b0;
            if (stamp_en) last_q[g] <= stamp_time;
         end
      end
   end

   assign scan_flags.referenced = ref_q[scan_idx];
   assign scan_flags.dirty      = dirty_q[scan_idx];
   assign scan_flags.pinned     = pin_q[scan_idx];
   assign scan_last             = last_q[scan_idx];

   assign rd_flags.referenced = ref_q[rd_idx];
   assign rd_flags.dirty      = dirty_q[rd_idx];
   assign rd_flags.pinned     = pin_q[rd_idx];
   assign rd_last             = last_q[rd_idx];

   assign pin_vec   = pin_q;
   assign dirty_vec = dirty_q;

   // R6: a pinned frame never has its flags touched by the sweep
   a_r6_pinned_untouched: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && scan_flags.pinned) |=> $stable(ref_q[$past(scan_idx)]));

   // R3: a cleared referenced flag stays cleared without a write
   a_r3_clear_sticks: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && !(wr_en && wr_idx == scan_idx)) |=> !ref_q[$past(scan_idx)]);

endmodule

// File: rtl/clk_age_test.sv
module clk_age_test #(
   parameter int TIME_W = 16,
   parameter bit WS_EN  = 1'b1
) (
   input  logic              ws_mode,
   input  logic [TIME_W-1:0] cur_time,
   input  logic [TIME_W-1:0] last_use,
   input  logic [TIME_W-1:0] window,
   output logic              young
);

   if (WS_EN) begin : g_age
      logic [TIME_W-1:0] elapsed;
      assign elapsed = cur_time - last_use;   // modular distance
      assign young   = ws_mode && (elapsed < window);
   end else begin : g_no_age
      logic unused_ok;
      assign unused_ok = ws_mode ^ (^cur_time) ^ (^last_use) ^ (^window);
      assign young     = 1'b0;
   end

endmodule

// File: rtl/clk_hand_fsm.sv
module clk_hand_fsm
   import clk_sel_pkg::*;
#(
   parameter int N_FRAMES = 64,
   parameter bit WS_EN    = 1'b1,
   parameter int IDX_W    = $clog2(N_FRAMES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_req,
   input  logic             ws_mode,
   input  frame_flags_t     flags,
   input  logic             young,
   input  logic             wb_ready,
   output logic [IDX_W-1:0] hand,
   output logic             clr_en,
   output logic             stamp_en,
   output logic             wb_valid,
   output logic [IDX_W-1:0] wb_idx,
   output logic             done,
   output logic             fail,
   output logic [IDX_W-1:0] victim,
   output logic             busy
);

   localparam int CNT_W     = $clog2(2 * N_FRAMES) + 1;
   localparam int LAST_STEP = 2 * N_FRAMES - 1;

   sweep_state_t     state;
   logic [CNT_W-1:0] steps;
   logic [IDX_W-1:0] hand_nxt;
   logic             advance, take, to_wb, last_step;

   assign hand_nxt  = (hand == IDX_W'(N_FRAMES - 1)) ? '0 : hand + 1'b1;
   assign last_step = (steps == CNT_W'(LAST_STEP));

   always_comb begin
      advance = 1'b0;
      take    = 1'b0;
      to_wb   = 1'b0;
      unique case (state)
         ST_SCAN: begin
            if (flags.pinned)          advance = 1'b1;
            else if (flags.referenced) advance = 1'b1;
            else if (young)            advance = 1'b1;
            else if (flags.dirty)      to_wb   = 1'b1;
            else                       take    = 1'b1;
         end
         ST_WB:   advance = wb_ready;
         default: ;
      endcase
   end

   assign clr_en   = (state == ST_SCAN) && !flags.pinned && flags.referenced;
   assign stamp_en = WS_EN && ws_mode && clr_en;
   assign wb_valid = (state == ST_WB);
   assign wb_idx   = hand;
   assign busy     = (state != ST_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         hand   <= '0;
         steps  <= '0;
         done   <= 1'b0;
         fail   <= 1'b0;
         victim <= '0;
      end else begin
         done <= 1'b0;
         fail <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (sel_req) begin
                  state <= ST_SCAN;
                  steps <= '0;
               end
            end
            ST_SCAN: begin
               if (take) begin
                  victim <= hand;
                  hand   <= hand_nxt;
                  done   <= 1'b1;
                  state  <= ST_IDLE;
               end else if (to_wb) begin
                  state <= ST_WB;
               end else if (advance) begin
                  hand  <= hand_nxt;
                  steps <= steps + 1'b1;
                  if (last_step) begin
                     fail  <= 1'b1;
                     state <= ST_IDLE;
                  end
               end
            end
            ST_WB: begin
               if (advance) begin
                  hand  <= hand_nxt;
                  steps <= steps + 1'b1;
                  if (last_step) begin
                     fail  <= 1'b1;
                     state <= ST_IDLE;
                  end else begin
                     state <= ST_SCAN;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // checker state: hand position when the sweep began
   logic [IDX_W-1:0] start_hand;
   always_ff @(posedge clk) begin
      if (!rst_n)                          start_hand <= '0;
      else if (state == ST_IDLE && sel_req) start_hand <= hand;
   end

   a_r5_done_fail_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && fail));

   a_r5_hand_past_victim: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (hand == ((victim == IDX_W'(N_FRAMES - 1)) ? '0 : victim + 1'b1)));

   a_r4_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_idx)));

   a_r2_idle_hand_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !sel_req) |=> $stable(hand));

   a_r9_fail_hand_home: assert property (@(posedge clk) disable iff (!rst_n)
      fail |-> (hand == start_hand && !busy));

endmodule

// File: rtl/clk_victim_sel.sv
module clk_victim_sel
   import clk_sel_pkg::*;
#(
   parameter int N_FRAMES = 64,
   parameter int TIME_W   = 16,
   parameter bit WS_EN    = 1'b1,
   localparam int IDX_W   = $clog2(N_FRAMES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ws_mode,
   input  logic [TIME_W-1:0] cur_time,
   input  logic [TIME_W-1:0] ws_window,
   input  logic              upd_en,
   input  logic [IDX_W-1:0]  upd_idx,
   input  logic              upd_ref,
   input  logic              upd_dirty,
   input  logic              upd_pin,
   input  logic [TIME_W-1:0] upd_last,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic              rd_ref,
   output logic              rd_dirty,
   output logic              rd_pin,
   output logic [TIME_W-1:0] rd_last,
   input  logic              sel_req,
   output logic              busy,
   output logic              done,
   output logic              fail,
   output logic [IDX_W-1:0]  victim,
   output logic [IDX_W-1:0]  hand,
   output logic              wb_valid,
   input  logic              wb_ready,
   output logic [IDX_W-1:0]  wb_idx
);

   if (N_FRAMES < 2) begin : g_bad_frames
      $error("clk_victim_sel: N_FRAMES must be at least 2");
   end
   if (TIME_W < 1) begin : g_bad_time
      $error("clk_victim_sel: TIME_W must be at least 1");
   end

   frame_flags_t        scan_flags, rd_flags;
   logic [TIME_W-1:0]   scan_last;
   logic                young, clr_en, stamp_en, wr_en;
   logic [N_FRAMES-1:0] pin_vec, dirty_vec;

   assign wr_en = upd_en && !busy;   // R10

   clk_frame_table #(
      .N_FRAMES(N_FRAMES), .TIME_W(TIME_W), .IDX_W(IDX_W)
   ) u_table (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_idx    (upd_idx),
      .wr_ref    (upd_ref),
      .wr_dirty  (upd_dirty),
      .wr_pin    (upd_pin),
      .wr_last   (upd_last),
      .clr_en    (clr_en),
      .stamp_en  (stamp_en),
      .stamp_time(cur_time),
      .scan_idx  (hand),
      .scan_flags(scan_flags),
      .scan_last (scan_last),
      .rd_idx    (rd_idx),
      .rd_flags  (rd_flags),
      .rd_last   (rd_last),
      .pin_vec   (pin_vec),
      .dirty_vec (dirty_vec)
   );

   clk_age_test #(.TIME_W(TIME_W), .WS_EN(WS_EN)) u_age (
      .ws_mode (ws_mode),
      .cur_time(cur_time),
      .last_use(scan_last),
      .window  (ws_window),
      .young   (young)
   );

   clk_hand_fsm #(.N_FRAMES(N_FRAMES), .WS_EN(WS_EN), .IDX_W(IDX_W)) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel_req (sel_req),
      .ws_mode (ws_mode),
      .flags   (scan_flags),
      .young   (young),
      .wb_ready(wb_ready),
      .hand    (hand),
      .clr_en  (clr_en),
      .stamp_en(stamp_en),
      .wb_valid(wb_valid),
      .wb_idx  (wb_idx),
      .done    (done),
      .fail    (fail),
      .victim  (victim),
      .busy    (busy)
   );

   assign rd_ref   = rd_flags.referenced;
   assign rd_dirty = rd_flags.dirty;
   assign rd_pin   = rd_flags.pinned;

   // R6: the chosen frame was not pinned
   a_r6_victim_unpinned: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !pin_vec[victim]);

   // R4: a write-back beat names a dirty, unpinned frame
   a_r4_wb_dirty_frame: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> (dirty_vec[wb_idx] && !pin_vec[wb_idx]));

   // R1: nothing is pending right after reset
   a_r1_quiet_after_reset: assert property (@(posedge clk)
      $rose(rst_n) |-> (!busy && !done && !fail && !wb_valid && hand == '0));

endmodule

// File: tb/clk_victim_sel_test.sv
module clk_victim_sel_test;

   localparam int N  = 64;
   localparam int TW = 16;
   localparam int IW = $clog2(N);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ws_mode = 1'b0;
   logic [TW-1:0] cur_time = '0, ws_window = '0;
   logic          upd_en = 1'b0, upd_ref = 1'b0, upd_dirty = 1'b0, upd_pin = 1'b0;
   logic [IW-1:0] upd_idx = '0, rd_idx = '0;
   logic [TW-1:0] upd_last = '0;
   logic          rd_ref, rd_dirty, rd_pin;
   logic [TW-1:0] rd_last;
   logic          sel_req = 1'b0, busy, done, fail, wb_valid, wb_ready = 1'b1;
   logic [IW-1:0] victim, hand, wb_idx;

   clk_victim_sel #(.N_FRAMES(N), .TIME_W(TW), .WS_EN(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .ws_mode(ws_mode), .cur_time(cur_time),
      .ws_window(ws_window), .upd_en(upd_en), .upd_idx(upd_idx),
      .upd_ref(upd_ref), .upd_dirty(upd_dirty), .upd_pin(upd_pin),
      .upd_last(upd_last), .rd_idx(rd_idx), .rd_ref(rd_ref),
      .rd_dirty(rd_dirty), .rd_pin(rd_pin), .rd_last(rd_last),
      .sel_req(sel_req), .busy(busy), .done(done), .fail(fail),
      .victim(victim), .hand(hand), .wb_valid(wb_valid),
      .wb_ready(wb_ready), .wb_idx(wb_idx)
   );

   always #10 clk = ~clk;   // 50 MHz

   int total = 0;
   int fails = 0;

   task automatic chk(input string req, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // reference model of the descriptor table
   bit            m_ref [N];
   bit            m_dirty [N];
   bit            m_pin [N];
   logic [TW-1:0] m_last [N];
   int            m_hand = 0;
   int            wbq[$];

   function automatic int model_select();
      for (int s = 0; s < 2 * N; s++) begin
         int i = m_hand;
         logic [TW-1:0] age = cur_time - m_last[i];
         m_hand = (m_hand + 1) % N;
         if (m_pin[i]) continue;
         if (m_ref[i]) begin
            if (ws_mode) m_last[i] = cur_time;
            m_ref[i] = 1'b0;
            continue;
         end
         if (ws_mode && age < ws_window) continue;
         if (m_dirty[i]) begin
            wbq.push_back(i);
            continue;
         end
         return i;
      end
      return -1;
   endfunction

   // write-back consumer / scoreboard monitor
   initial begin
      int cyc = 0;
      forever begin
         @(negedge clk);
         if (wb_valid && wb_ready) begin
            if (wbq.size() == 0) chk("R4 unexpected write-back", wb_idx, -1);
            else chk("R4 write-back index", wb_idx, wbq.pop_front());
         end
         cyc++;
         wb_ready = (cyc % 3) != 0;
      end
   end

   task automatic wr(input int idx, input bit r, input bit d, input bit p,
                     input logic [TW-1:0] l);
      @(negedge clk);
      upd_en = 1'b1; upd_idx = IW'(idx);
      upd_ref = r; upd_dirty = d; upd_pin = p; upd_last = l;
      m_ref[idx] = r; m_dirty[idx] = d; m_pin[idx] = p; m_last[idx] = l;
      @(negedge clk);
      upd_en = 1'b0;
   endtask

   int exp_v;

   task automatic start_sel();
      exp_v = model_select();
      @(negedge clk); sel_req = 1'b1;
      @(negedge clk); sel_req = 1'b0;
   endtask

   task automatic finish_sel(input string tag);
      int k = 0;
      while (!(done || fail) && k < 1000) begin
         @(negedge clk);
         k++;
      end
      if (exp_v < 0) chk({tag, " fail pulse"}, fail, 1);
      else begin
         chk({tag, " done pulse"}, done, 1);
         chk({tag, " victim"}, victim, exp_v);
      end
      chk({tag, " hand after"}, hand, m_hand);
      chk({tag, " write-backs drained"}, wbq.size(), 0);
   endtask

   task automatic rd_at(input int idx);
      rd_idx = IW'(idx);
      #1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1 hand", hand, 0);
      chk("R1 busy", busy, 0);
      chk("R1 wb_valid", wb_valid, 0);
      rd_at(10);
      chk("R1 fields", {rd_ref, rd_dirty, rd_pin, rd_last}, 0);

      // R2 R5: clean table, victim at hand 0
      start_sel(); finish_sel("R2 R5 clean table");

      // R3 R4 R5: referenced 1,2 ; dirty 3 ; victim 4
      wr(1, 1, 0, 0, 0); wr(2, 1, 0, 0, 0); wr(3, 0, 1, 0, 0);
      start_sel(); finish_sel("R4 R5 mixed");
      rd_at(1); chk("R3 ref cleared", rd_ref, 0);
      rd_at(3); chk("R4 dirty kept", rd_dirty, 1);

      // R6: pinned referenced frame 5 skipped, untouched
      wr(5, 1, 1, 1, 16'd7);
      start_sel(); finish_sel("R6 pinned skip");
      rd_at(5);
      chk("R6 pinned untouched", {rd_ref, rd_dirty, rd_pin, rd_last}, {3'b111, 16'd7});

      // R11 R4: long run of dirty frames, victim 63, hand wraps to 0
      wr(5, 0, 0, 0, 0);
      for (int i = 7; i < 63; i++) wr(i, 0, 1, 0, 0);
      start_sel(); finish_sel("R11 wrap");

      // R9: everything pinned
      for (int i = 0; i < N; i++) wr(i, 0, 0, 1, 0);
      start_sel(); finish_sel("R9 all pinned");

      // R3: everything referenced, second revolution picks the start frame
      for (int i = 0; i < N; i++) wr(i, 1, 0, 0, 0);
      start_sel(); finish_sel("R3 all referenced");
      rd_at(30); chk("R3 ref cleared far", rd_ref, 0);

      // R7 R8: working-set mode
      ws_mode = 1'b1; cur_time = 16'd1000; ws_window = 16'd100;
      wr(1, 1, 0, 0, 16'd5); wr(2, 0, 0, 0, 16'd950); wr(3, 0, 0, 0, 16'd800);
      start_sel(); finish_sel("R8 window");
      rd_at(1); chk("R7 last-use stamped", rd_last, 1000);
      rd_at(2); chk("R8 young frame kept", rd_last, 950);

      // R8: modular age across time wrap
      cur_time = 16'd20;
      wr(4, 0, 0, 0, 16'd65500); wr(5, 0, 0, 0, 16'd65000);
      start_sel(); finish_sel("R8 time wrap");

      // R10: write offered mid-sweep is dropped
      ws_mode = 1'b0;
      for (int i = 0; i < N; i++) wr(i, 0, 0, (i != 50), 0);
      start_sel();
      @(negedge clk);
      upd_en = 1'b1; upd_idx = IW'(60); upd_ref = 1'b1; upd_dirty = 1'b1;
      upd_pin = 1'b0; upd_last = 16'd99;
      @(negedge clk);
      upd_en = 1'b0;
      finish_sel("R10 busy write");
      rd_at(60);
      chk("R10 write dropped", {rd_ref, rd_dirty, rd_pin, rd_last}, {3'b001, 16'd0});

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      #(20 * 150000);
      fails++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule